// File: doc/BRIEF.md
# Programmable Serial Bit-Clock Divider

This block turns the input clock of a sample-rate generator into a slower serial bit clock. An 8-bit divide-down value is written through a simple write port. The bit clock then runs at the input frequency divided by (value + 1), so any ratio from 1 to 256 is available. Alongside the clock level, the block gives a one-cycle strobe at the start of every bit-clock period. Later frame-sync stages can count this strobe without needing their own edge detection.

The core is a small phase state machine with a down-counter. Its states are ST_HIGH (the high phase, counting down), ST_LOW (the low phase, counting down) and ST_BYPASS (divide-by-1, where the input clock itself is passed through). The machine moves between states on these transitions:

- High-to-low: when the high count is used up.
- Period start: when the low count is used up. The new period enters ST_HIGH for a nonzero value, or ST_BYPASS for zero.
- Bypass re-evaluation: on every cycle in ST_BYPASS, the stored value is checked again as a new period start.

Reset places the machine in ST_LOW with an empty counter, so the first period starts on the first edge after release. Odd values give an even ratio with equal phases. Even values give an odd ratio, where the high phase is one cycle longer than the low phase.

Top module: `bclk_divider`

## Requirements
- R1: The spacing between consecutive period-start strobes is (v + 1) input cycles, where v is the 8-bit divide value latched for that period; v ranges over 0..255.
- R2: While the active-low synchronous reset is sampled low, the clock output and the strobe are 0 after that edge, and the divide value returns to 1 (divide by 2).
- R3: For an odd value v, the output is high for (v + 1)/2 cycles and then low for (v + 1)/2 cycles.
- R4: For an even nonzero value v = 2p, the output is high for p + 1 cycles and then low for p cycles.
- R5: For v = 0, the output follows the input clock (high during the high half of each input cycle), and the strobe is 1 on every cycle.
- R6: Every period starts with its high phase, and the strobe is 1 for exactly the first cycle of each period.
- R7: A write is accepted on any cycle. A period uses the value held in the register at the edge that starts it, so a write never shortens or stretches the current period. A write on that same edge applies from the following period.
- R8: The first high phase and strobe appear on the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-rate generator input clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| div_wr_i | input | 1 | Write enable for the divide value |
| div_wdata_i | input | 8 | Divide value v to store (ratio v + 1) |
| bclk_o | output | 1 | Divided bit-clock level |
| bclk_start_o | output | 1 | One-cycle strobe at the start of each bit-clock period |

## Verification
The bench builds the block with its default 8-bit value width, so the full ratio range from the bypass case at 1 up to 256 is reachable. It runs the extremes 0, 1, 254 and 255 alongside small odd and even values. Writes are placed in the middle of high and low phases, back to back, and directly before and after bypass. This exercises the deferred-reload rule at every kind of period boundary, including resets during a long period.

// File: rtl/bclk_div_pkg.sv
package bclk_div_pkg;

    // Phase states of the bit-clock sequencer
    typedef enum logic [1:0] {
        ST_HIGH   = 2'd0,
        ST_LOW    = 2'd1,
        ST_BYPASS = 2'd2
    } bclk_phase_e;

endpackage

// File: rtl/bclk_cfg_reg.sv
module bclk_cfg_reg #(
    parameter int DIV_W     = 8,
    parameter int RESET_DIV = 1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             wr_i,
    input  logic [DIV_W-1:0] wdata_i,
    output logic [DIV_W-1:0] div_o
);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            div_q <= DIV_W'(RESET_DIV);
        end else if (wr_i) begin
            div_q <= wdata_i;
        end
    end

    assign div_o = div_q;

    // R7
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wr_i |=> $stable(div_q));

endmodule

// File: rtl/bclk_phase_fsm.sv
module bclk_phase_fsm
    import bclk_div_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int RESET_DIV = 1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             level_o,
    output logic             start_o,
    output logic             bypass_o
);

    localparam logic [DIV_W-1:0] CNT_ZERO = '0;

    // High phase gets the larger half of an odd ratio
    function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] d);
        return (d >> 1) + DIV_W'(1);
    endfunction

    function automatic logic [DIV_W-1:0] low_len(input logic [DIV_W-1:0] d);
        return d - (d >> 1);
    endfunction

    bclk_phase_e      state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] act_q, act_d;
    logic             period_start;
    logic             level_q, start_q;

    // Next-state logic
    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        act_d        = act_q;
        period_start = 1'b0;
        unique case (state_q)
            ST_HIGH: begin
                if (cnt_q == CNT_ZERO) begin
                    state_d = ST_LOW;
                    cnt_d   = low_len(act_q) - DIV_W'(1);
                end else begin
                    cnt_d = cnt_q - DIV_W'(1);
                end
            end
            ST_LOW: begin
                if (cnt_q == CNT_ZERO) begin
                    period_start = 1'b1;
                end else begin
                    cnt_d = cnt_q - DIV_W'(1);
                end
            end
            ST_BYPASS: period_start = 1'b1;
            default:   period_start = 1'b1;
        endcase
        if (period_start) begin
            act_d = div_i;
            if (div_i == CNT_ZERO) begin
                state_d = ST_BYPASS;
                cnt_d   = CNT_ZERO;
            end else begin
                state_d = ST_HIGH;
                cnt_d   = high_len(div_i) - DIV_W'(1);
            end
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= ST_LOW;
            cnt_q   <= CNT_ZERO;
            act_q   <= DIV_W'(RESET_DIV);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            level_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            level_q <= (state_d == ST_HIGH);
            start_q <= period_start;
        end
    end

    assign level_o  = level_q;
    assign start_o  = start_q;
    assign bypass_o = (state_q == ST_BYPASS);

    // R2
    rst_quiet_chk: assert property (@(posedge clk_i)
        !rst_n_i |=> (!level_q && !start_q));

    // R8
    start_after_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_LOW && cnt_q == CNT_ZERO) |=> start_q);

    // R6
    rise_has_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(level_q) |-> start_q);

    // R6
    start_is_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (start_q && state_q != ST_BYPASS) |-> level_q);

    // R7
    period_value_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_HIGH || (state_q == ST_LOW && cnt_q != CNT_ZERO))
        |=> $stable(act_q));

    // R3
    high_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_HIGH) |-> (cnt_q < high_len(act_q)));

endmodule

// File: rtl/bclk_out_mux.sv
module bclk_out_mux (
    input  logic clk_i,
    input  logic bypass_i,
    input  logic level_i,
    output logic bclk_o
);

    always_comb begin
        bclk_o = bypass_i ? clk_i : level_i;
    end

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider #(
    parameter int DIV_W     = 8,
    parameter int RESET_DIV = 1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_wdata_i,
    output logic             bclk_o,
    output logic             bclk_start_o
);

    logic [DIV_W-1:0] div_val;
    logic             level;
    logic             bypass;

    bclk_cfg_reg #(
        .DIV_W     (DIV_W),
        .RESET_DIV (RESET_DIV)
    ) i_cfg (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .wr_i    (div_wr_i),
        .wdata_i (div_wdata_i),
        .div_o   (div_val)
    );

    bclk_phase_fsm #(
        .DIV_W     (DIV_W),
        .RESET_DIV (RESET_DIV)
    ) i_fsm (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .div_i    (div_val),
        .level_o  (level),
        .start_o  (bclk_start_o),
        .bypass_o (bypass)
    );

    bclk_out_mux i_mux (
        .clk_i    (clk_i),
        .bypass_i (bypass),
        .level_i  (level),
        .bclk_o   (bclk_o)
    );

endmodule

// File: tb/test_bclk_divider.sv
`timescale 1ns/1ps
module test_bclk_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       bclk;
    logic       strobe;

    always #2.5 clk = ~clk;

    bclk_divider i_bclk_divider (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .div_wr_i     (wr_en),
        .div_wdata_i  (wr_data),
        .bclk_o       (bclk),
        .bclk_start_o (strobe)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // Reference model state
    int  m_field = 1;
    int  cur_n   = 2;
    int  pos     = 0;
    bit  start_next = 1'b1;
    bit  prev_rst = 1'b1;
    bit  wrote_in_period = 1'b0;
    int  exp_gap = 0;
    int  dut_gap = 0;
    bit  have_prev = 1'b0;

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: got %0b expected %0b", req, what, $time, got, exp);
        end
    endtask

    // Cycle-by-cycle reference and compare
    initial begin : monitor
        logic r, we;
        logic [7:0] wd;
        logic exp_l, exp_s;
        string tag;
        forever begin
            @(posedge clk);
            r = rst_n; we = wr_en; wd = wr_data;
            #1;
            if (!r) begin
                m_field = 1; start_next = 1'b1; exp_l = 1'b0; exp_s = 1'b0;
                have_prev = 1'b0; wrote_in_period = 1'b0;
                tag = "R2";
            end else begin
                if (start_next) begin
                    exp_gap = cur_n;
                    cur_n = m_field + 1;
                    pos = 0;
                    wrote_in_period = 1'b0;
                end else begin
                    pos++;
                end
                start_next = (pos == cur_n - 1);
                if (cur_n == 1) begin
                    exp_l = 1'b1; exp_s = 1'b1; tag = "R5";
                end else begin
                    exp_s = (pos == 0);
                    exp_l = (pos < (cur_n + 1) / 2);
                    if (!prev_rst)            tag = "R8";
                    else if (wrote_in_period) tag = "R7";
                    else if (exp_s)           tag = "R6";
                    else if (cur_n % 2 == 0)  tag = "R3";
                    else                      tag = "R4";
                end
                if (we) begin
                    m_field = wd;
                    wrote_in_period = 1'b1;
                end
            end
            check(bclk, exp_l, tag, "bit clock level");
            check(strobe, exp_s, tag, "period strobe");
            // R1: strobe spacing measured at the outputs
            if (r) begin
                dut_gap++;
                if (strobe === 1'b1) begin
                    if (have_prev) begin
                        checks++;
                        if (dut_gap != exp_gap) begin
                            fails++;
                            $display("FAIL R1 strobe spacing at %0t: got %0d expected %0d",
                                     $time, dut_gap, exp_gap);
                        end
                    end
                    have_prev = 1'b1;
                    dut_gap = 0;
                end
            end else begin
                dut_gap = 0;
            end
            prev_rst = r;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_div(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        idle(n);
        rst_n = 1'b1;
    endtask

    initial begin : stimulus
        idle(3);
        rst_n = 1'b1;
        idle(12);
        foreach (sweep[i]) begin
            write_div(sweep[i]);
            idle(3 * (int'(sweep[i]) + 1) + 4);
        end
        // R7: back-to-back writes within one period, last one wins
        write_div(8'd9);
        idle(3);
        write_div(8'd4);
        write_div(8'd3);
        idle(30);
        // enter and leave bypass quickly
        write_div(8'd0);
        write_div(8'd2);
        idle(12);
        write_div(8'd0);
        idle(5);
        write_div(8'd6);
        idle(20);
        // reset in the middle of a long period
        write_div(8'd20);
        idle(30);
        do_reset(2);
        idle(12);
        write_div(8'd255);
        idle(100);
        do_reset(1);
        idle(10);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    logic [7:0] sweep [11] = '{8'd1, 8'd3, 8'd2, 8'd4, 8'd0, 8'd7, 8'd6,
                               8'd255, 8'd254, 8'd0, 8'd5};

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at %0t: got running expected finished", $time);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule